// File: doc/BRIEF.md
# Tapped Binary Divider Chain

This block divides a slow source waveform by powers of two. It holds a chain of fourteen binary stages. Every falling transition of the source input adds one to the chain, and each stage runs at half the rate of the stage below it. Only ten of the stages are visible: stages 3 to 9 and stages 11 to 13. Stages 0, 1, 2 and 10 stay inside. Use it for frequency division, timers and delay generation, wherever a coarse set of divided-down strobes is enough.

The source input can be any waveform that is slow next to the system clock: an external clock, or the squared-up output of an oscillator. It is passed through a synchronizer and sampled on the system clock, so all state lives in one clock domain. A high-active clear input takes priority over counting. It forces the visible outputs low in the same cycle, without waiting for a clock edge, and holds the chain at zero for as long as it stays high. A synchronous active-low reset also returns the chain to zero.

Top module: `tapdiv_chain`

## Requirements
- R1: The chain advances by exactly one for each falling transition of `src_in` that the block detects. Rising transitions and steady levels leave it unchanged.
- R2: While `clr` is high, `taps` reads all zeros in the same cycle, and the chain is held at zero. A falling transition of `src_in` that occurs while `clr` is high is discarded, provided `clr` stays high for at least three `clk` cycles after that transition.
- R3: After 16384 counted falls from zero, the chain wraps from all ones to zero. No carry or overflow indication is produced.
- R4: The output bits map to chain bits as follows: `taps[6:0]` carries chain bits 3 to 9, and `taps[9:7]` carries chain bits 11 to 13. Chain bits 0, 1, 2 and 10 never appear on `taps`, so a count of 1024 reads as all zeros.
- R5: A fall of `src_in` made between clock edges appears on `taps` right after the third following rising edge of `clk`. After the first and second edges, `taps` still shows the old value.
- R6: When `rst_n` is low at a rising edge of `clk`, the chain is cleared to zero.
- R7: Each stage toggles when the stage below it goes from 1 to 0, so output `taps[0]` is low for the first 8 falls, high for the next 8, and repeats with a period of 16 falls.
- R8: A falling transition of `src_in` that occurs after `clr` has gone low is counted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 1 | Source waveform; each falling transition advances the chain |
| clr | input | 1 | High-active overriding clear |
| taps | output | 10 | Visible stage outputs (chain bits 3 to 9, 11 to 13) |

## Verification
The hardest case to reach from the ports is the wrap from all ones to zero. The visible outputs only show that state after the full cycle of 16384 source falls. The stimulus table walks the count to that point in large steps, checking on the way at counts whose only set bit is hidden (1024). A second hard case is a source fall swallowed by the clear. It is reached by pulsing the source while the clear is high and then counting seven falls after release, so that one extra counted fall would show up as a high first output.

// File: rtl/tapdiv_pkg.sv
// Package: helpers shared by the tapped divider chain.
// Assumes tap masks fit in 64 bits.
package tapdiv_pkg;

    // Number of set bits in a tap mask.
    function automatic int tap_count(input logic [63:0] mask);
        int n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (mask[i]) n++;
        end
        return n;
    endfunction

    // Bit position of the k-th set bit (counted from bit 0) of a tap mask.
    function automatic int tap_pos(input logic [63:0] mask, input int k);
        int seen;
        int pos;
        seen = 0;
        pos  = 0;
        for (int i = 0; i < 64; i++) begin
            if (mask[i]) begin
                if (seen == k) pos = i;
                seen++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/tapdiv_edge.sv
// Module: tapdiv_edge
// Brings the slow source into the clk domain and flags its falling transitions.
// Assumes SYNC_STAGES >= 2 and a source level that holds for at least
// SYNC_STAGES+1 clk cycles between transitions.
module tapdiv_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the source through the synchronizer and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // A fall is a high-to-low step of the synchronized level.
    assign fall = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/tapdiv_count.sv
// Module: tapdiv_count
// Binary chain of STAGES bits. Each bit toggles when the bit below it
// goes from 1 to 0. Assumes step arrives as a single-cycle pulse.
module tapdiv_count #(
    parameter int STAGES = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [STAGES-1:0] cnt
);

    logic [STAGES-1:0] toggle;

    // Stage 0 toggles on each step; higher stages follow when the one below wraps.
    assign toggle[0] = step;
    for (genvar i = 1; i < STAGES; i++) begin : g_ripple
        assign toggle[i] = toggle[i-1] & cnt[i-1];
    end

    // Hold the chain; clear and reset take priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt ^ toggle;
        end
    end

endmodule

// File: rtl/tapdiv_taps.sv
// Module: tapdiv_taps
// Picks the chain bits named by TAP_MASK, lowest first, and forces them
// low while clr is high. Assumes TAP_MASK has at least one bit set.
module tapdiv_taps #(
    parameter int                 STAGES   = 14,
    parameter logic [STAGES-1:0]  TAP_MASK = 14'h3BF8,
    localparam int                NUM_TAPS = tapdiv_pkg::tap_count(64'(TAP_MASK))
) (
    input  logic [STAGES-1:0]   cnt,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] taps
);

    logic [NUM_TAPS-1:0] raw;

    // Route each selected chain bit to its output slot.
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam int POS = tapdiv_pkg::tap_pos(64'(TAP_MASK), k);
        assign raw[k] = cnt[POS];
    end

    // Clear overrides the outputs without waiting for a clock edge.
    always_comb begin
        taps = clr ? '0 : raw;
    end

endmodule

// File: rtl/tapdiv_chain.sv
// Module: tapdiv_chain (top)
// Divider chain advanced by falling transitions of src_in, with ten visible
// stages and an overriding high-active clear. Assumes src_in changes slowly
// next to clk (each level held at least SYNC_STAGES+1 cycles).
module tapdiv_chain #(
    parameter int                STAGES      = 14,
    parameter logic [STAGES-1:0] TAP_MASK    = 14'h3BF8,
    parameter int                SYNC_STAGES = 2,
    localparam int               NUM_TAPS    = tapdiv_pkg::tap_count(64'(TAP_MASK))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_in,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] taps
);

    logic              src_fall;
    logic [STAGES-1:0] cnt_q;

    tapdiv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_in),
        .fall  (src_fall)
    );

    tapdiv_count #(.STAGES(STAGES)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (src_fall),
        .cnt   (cnt_q)
    );

    tapdiv_taps #(.STAGES(STAGES), .TAP_MASK(TAP_MASK)) u_taps (
        .cnt   (cnt_q),
        .clr   (clr),
        .taps  (taps)
    );

endmodule

// File: rtl/tapdiv_chain_chk.sv
// Module: tapdiv_chain_chk
// Checker bound into tapdiv_chain; watches the chain against its step and clear inputs.
module tapdiv_chain_chk #(
    parameter int STAGES = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              fall,
    input logic [STAGES-1:0] cnt
);

    // R6: reset clears the chain.
    a_r6_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0));

    // R2: clear holds the chain at zero.
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R1: with no fall and no clear, the chain holds.
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !clr) |=> $stable(cnt));

    // R3: wrap from all ones to zero.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt) && fall && !clr) |=> (cnt == '0));

    // R7: each stage toggles when the one below it falls while counting.
    for (genvar i = 1; i < STAGES; i++) begin : g_rip
        a_r7_ripple: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(clr) && $fell(cnt[i-1])) |-> (cnt[i] != $past(cnt[i])));
    end

endmodule

bind tapdiv_chain tapdiv_chain_chk #(.STAGES(STAGES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .fall  (src_fall),
    .cnt   (cnt_q)
);

// File: tb/tapdiv_chain_tb.sv
`timescale 1ns/1ps
module tapdiv_chain_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_in = 1'b0;
    logic       clr = 1'b0;
    logic [9:0] taps;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tapdiv_chain u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .clr    (clr),
        .taps   (taps)
    );

    // Stimulus table: falls to apply, then the expected chain value.
    localparam int NSTEP = 9;
    localparam int STEP_N [NSTEP] = '{1, 7, 8, 1008, 8, 1016, 6143, 8192, 1};
    localparam int STEP_V [NSTEP] = '{1, 8, 16, 1024, 1032, 2048, 8191, 16383, 0};

    // Expected visible bits for a chain value (R4 mapping).
    function automatic logic [9:0] exp_taps(input int c);
        logic [13:0] v;
        v = 14'(c);
        return {v[13:11], v[9:3]};
    endfunction

    task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: taps=%h expected=%h", req, got, exp);
        end
    endtask

    // One full source period: high then low, each for three clk cycles.
    task automatic pulse();
        src_in = 1'b1;
        repeat (3) @(negedge clk);
        src_in = 1'b0;
        repeat (3) @(negedge clk);
        if (!clr) model = (model + 1) % 16384;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R6 reset state", taps, 10'h000);

        // R1 R3 R4: table walk through hidden bit 10 and the wrap.
        for (int s = 0; s < NSTEP; s++) begin
            for (int p = 0; p < STEP_N[s]; p++) pulse();
            #1 check($sformatf("R1/R4/R3 step %0d", s), taps, exp_taps(STEP_V[s]));
        end
        check("R3 wrap model", exp_taps(model), 10'h000);

        // R7: first output period of 16 falls.
        @(negedge clk); do_reset();
        for (int i = 1; i <= 16; i++) begin
            pulse();
            #1 check($sformatf("R7 fall %0d", i), {9'h0, taps[0]}, {9'h0, 1'(((i >> 3) & 1))});
        end

        // R5: latency of a fall to the outputs (7 -> 8).
        @(negedge clk); do_reset();
        for (int i = 0; i < 7; i++) pulse();
        src_in = 1'b1;
        repeat (3) @(negedge clk);
        src_in = 1'b0;
        @(negedge clk); #1 check("R5 after edge 1", taps, 10'h000);
        @(negedge clk); #1 check("R5 after edge 2", taps, 10'h000);
        @(negedge clk); #1 check("R5 after edge 3", taps, 10'h001);

        // R2 R8: clear mid-count, swallowed fall, count after release.
        @(negedge clk); do_reset();
        for (int i = 0; i < 37; i++) pulse();
        #1 check("R2 before clear", taps, exp_taps(37));
        @(negedge clk);
        clr = 1'b1;
        #1 check("R2 immediate low", taps, 10'h000);
        pulse();
        repeat (2) @(negedge clk);
        #1 check("R2 held low", taps, 10'h000);
        @(negedge clk);
        clr = 1'b0;
        model = 0;
        for (int i = 0; i < 7; i++) pulse();
        #1 check("R2 fall during clear discarded", taps, 10'h000);
        pulse();
        #1 check("R8 counting after release", taps, 10'h001);

        // R6: reset mid-count.
        for (int i = 0; i < 100; i++) pulse();
        #1 check("R6 before reset", taps, exp_taps(model));
        @(negedge clk); do_reset();
        #1 check("R6 mid-count reset", taps, 10'h000);
        for (int i = 0; i < 8; i++) pulse();
        #1 check("R6 count after reset", taps, 10'h001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule